// File: doc/BRIEF.md
# Serial Command Register Decoder

This block sits at the serial control port of a data converter. A host shifts 16-bit command words in on a serial clock while an active-low select is held low. The block checks that exactly sixteen bits arrived, moves the finished word into the system clock domain and decodes it there. The decoded word is written into one of the converter's configuration registers. The most significant bit of the word splits the code space. When that bit is clear, the rest of the word belongs to one mode-control register. When it is set, a four-bit target code picks one of seven 11-bit data registers.

The mode-control register holds three fields: a scan-control field, a channel-select field and a reset field. The reset field is an action and is not stored. It can raise a one-cycle strobe that empties the result FIFO, or it can return every register to its power-up value and also raise that strobe. The register contents and the FIFO-clear strobe go to the rest of the converter. That logic is not part of this block.

Top module: `serial_cmd_decoder`

## Requirements
- R1: After the hardware reset `rstN` is released, `modeCtl` reads 15'h0800 (scan field bits 14:11 = 0001, channel field bits 10:7 = 0000), every slot of `cfgBank` reads zero, and `fifoClr` is low.
- R2: A frame is the run of `din` bits sampled on rising `sclk` edges while `csN` is low, most significant bit first. A frame is decoded only if exactly 16 such edges occurred before `csN` rises. A frame of 15 or 17 bits changes no register and raises no strobe.
- R3: A word with bit 15 = 0 writes bits 14:0 into `modeCtl`. Bits 6:5 of `modeCtl` (the reset field) always read 00.
- R4: A word with bit 15 = 1 and target code bits 14:11 in 0..6 writes bits 10:0 into slot k = code of `cfgBank`, at bits [11k+10:11k]. The codes are 0 configuration, 1 unipolar, 2 bipolar, 3 range, 4 custom scan 0, 5 custom scan 1, 6 sample set. All other slots and `modeCtl` are unchanged.
- R5: A word with bit 15 = 1 and target code 7..15 (15 is reserved) changes no register and raises no strobe.
- R6: A mode word with reset field 01 raises `fifoClr` for exactly one cycle. It stores its other mode bits and leaves `cfgBank` unchanged.
- R7: A mode word with reset field 10 returns `modeCtl` and `cfgBank` to their R1 values and raises `fifoClr` for exactly one cycle.
- R8: A mode word with reset field 00 or 11 stores its mode bits and does not raise `fifoClr`.
- R9: Each valid frame is decoded exactly once. Its register update and its `fifoClr` pulse appear on the same clock edge, and no register changes without a decoded frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| sclk | input | 1 | Serial shift clock, data sampled on rising edge |
| csN | input | 1 | Active-low frame select; rising edge ends a frame |
| din | input | 1 | Serial command data, MSB first |
| modeCtl | output | 15 | Mode-control register: scan 14:11, channel 10:7, reset field 6:5 (reads 00), 4:0 |
| cfgBank | output | 77 | Seven 11-bit data registers, slot k at bits [11k+10:11k] |
| fifoClr | output | 1 | One-cycle FIFO-clear strobe |

## Verification
On every cycle the assertions check four things. The FIFO-clear strobe lasts one cycle and follows only a reset command. Registers stay still in any cycle without a decoded frame. Reserved target codes leave everything untouched, and a restore command lands on the default values. The stored reset field is also checked to stay at 00. Some properties can only be shown by the bench, which drives real serial frames. These are the counting of exactly sixteen bits, the bit order, the crossing into the system clock domain producing exactly one decode for each frame, and the register values after sweeps over every target code and every combination of reset field and scan field.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int WORD_W    = 16;
  localparam int MODE_W    = WORD_W - 1;
  localparam int DATA_W    = 11;
  localparam int CODE_W    = 4;
  localparam int CODE_LSB  = DATA_W;
  localparam int DATA_REGS = 7;
  localparam int RST_LSB   = 5;
  localparam int CNT_W     = $clog2(WORD_W + 2);
  localparam logic [MODE_W-1:0] MODE_DEFAULT = 15'h0800;

  typedef struct packed {
    logic                  wrMode;
    logic [DATA_REGS-1:0]  wrData;
    logic                  clrFifo;
    logic                  restoreAll;
    logic [MODE_W-1:0]     modeVal;
    logic [DATA_W-1:0]     dataVal;
  } cmd_stb_t;
endpackage

// File: rtl/cmd_dec_serial.sv
module cmd_dec_serial
  import cmd_dec_pkg::*;
(
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              din,
  output logic              frameTgl,
  output logic [WORD_W-1:0] frameWord
);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shiftQ;
  logic [CNT_W-1:0]  bitCnt;

  always_ff @(posedge sclk) begin
    if (!csN) shiftQ <= {shiftQ[WORD_W-2:0], din};
  end

  // counter held clear while select is high; saturates past a full word
  always_ff @(posedge sclk or posedge csN) begin
    if (csN) bitCnt <= '0;
    else if (bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
  end

  // frame end: latch word and flip toggle only on an exact-length frame
  always_ff @(posedge csN or negedge rstN) begin
    if (!rstN) begin
      frameTgl  <= 1'b0;
      frameWord <= '0;
    end else if (bitCnt == CNT_FULL) begin
      frameWord <= shiftQ;
      frameTgl  <= ~frameTgl;
    end
  end
endmodule

// File: rtl/cmd_dec_ctrl.sv
module cmd_dec_ctrl
  import cmd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTgl,
  input  logic [WORD_W-1:0] frameWord,
  output logic              frameStb,
  output cmd_stb_t          cmdStb
);
  logic [2:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], frameTgl};
  end

  // word is held stable from the toggle flip until the next frame end
  assign frameStb = syncQ[2] ^ syncQ[1];

  logic              isMode;
  logic [CODE_W-1:0] tgtCode;
  logic [1:0]        rstField;

  assign isMode   = ~frameWord[WORD_W-1];
  assign tgtCode  = frameWord[CODE_LSB +: CODE_W];
  assign rstField = frameWord[RST_LSB +: 2];

  always_comb begin
    cmdStb.wrMode     = frameStb & isMode;
    cmdStb.restoreAll = frameStb & isMode & (rstField == 2'b10);
    cmdStb.clrFifo    = frameStb & isMode & ((rstField == 2'b01) | (rstField == 2'b10));
    cmdStb.modeVal    = frameWord[MODE_W-1:0];
    cmdStb.modeVal[RST_LSB +: 2] = 2'b00;
    cmdStb.dataVal    = frameWord[DATA_W-1:0];
  end

  for (genvar k = 0; k < DATA_REGS; k++) begin : g_sel
    assign cmdStb.wrData[k] = frameStb & ~isMode & (tgtCode == CODE_W'(k));
  end
endmodule

// File: rtl/cmd_dec_regs.sv
module cmd_dec_regs
  import cmd_dec_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  cmd_stb_t                    cmdStb,
  output logic [MODE_W-1:0]           modeCtl,
  output logic [DATA_REGS*DATA_W-1:0] cfgBank,
  output logic                        fifoClr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeCtl <= MODE_DEFAULT;
      fifoClr <= 1'b0;
    end else begin
      fifoClr <= cmdStb.clrFifo;
      if (cmdStb.restoreAll)  modeCtl <= MODE_DEFAULT;
      else if (cmdStb.wrMode) modeCtl <= cmdStb.modeVal;
    end
  end

  for (genvar k = 0; k < DATA_REGS; k++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  cfgBank[k*DATA_W +: DATA_W] <= '0;
      else if (cmdStb.restoreAll) cfgBank[k*DATA_W +: DATA_W] <= '0;
      else if (cmdStb.wrData[k])  cfgBank[k*DATA_W +: DATA_W] <= cmdStb.dataVal;
    end
  end
endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
  import cmd_dec_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclk,
  input  logic                        csN,
  input  logic                        din,
  output logic [MODE_W-1:0]           modeCtl,
  output logic [DATA_REGS*DATA_W-1:0] cfgBank,
  output logic                        fifoClr
);
  logic              frameTgl;
  logic [WORD_W-1:0] frameWord;
  logic              frameStb;
  cmd_stb_t          cmdStb;

  cmd_dec_serial u_serial (
    .rstN(rstN), .sclk(sclk), .csN(csN), .din(din),
    .frameTgl(frameTgl), .frameWord(frameWord)
  );

  cmd_dec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameTgl(frameTgl), .frameWord(frameWord),
    .frameStb(frameStb), .cmdStb(cmdStb)
  );

  cmd_dec_regs u_regs (
    .clk(clk), .rstN(rstN), .cmdStb(cmdStb),
    .modeCtl(modeCtl), .cfgBank(cfgBank), .fifoClr(fifoClr)
  );
endmodule

// File: rtl/cmd_dec_check.sv
module cmd_dec_check
  import cmd_dec_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        frameStb,
  input logic [WORD_W-1:0]           frameWord,
  input logic [MODE_W-1:0]           modeCtl,
  input logic [DATA_REGS*DATA_W-1:0] cfgBank,
  input logic                        fifoClr
);
  logic modeWord, clrCmd, restoreCmd, reservedCmd;
  assign modeWord    = frameStb & ~frameWord[WORD_W-1];
  assign clrCmd      = modeWord & (frameWord[RST_LSB +: 2] == 2'b01);
  assign restoreCmd  = modeWord & (frameWord[RST_LSB +: 2] == 2'b10);
  assign reservedCmd = frameStb & frameWord[WORD_W-1] &
                       (frameWord[CODE_LSB +: CODE_W] >= CODE_W'(DATA_REGS));

  assert_rst_field_R3: assert property (@(posedge clk) disable iff (!rstN)
    modeCtl[RST_LSB +: 2] == 2'b00);

  assert_reserved_R5: assert property (@(posedge clk) disable iff (!rstN)
    reservedCmd |=> $stable(modeCtl) && $stable(cfgBank) && !fifoClr);

  assert_clr_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |-> $past(clrCmd || restoreCmd));

  assert_restore_R7: assert property (@(posedge clk) disable iff (!rstN)
    restoreCmd |=> (modeCtl == MODE_DEFAULT) && (cfgBank == '0) && fifoClr);

  assert_clr_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> !fifoClr);

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(frameStb) |-> $stable(modeCtl) && $stable(cfgBank));
endmodule

bind serial_cmd_decoder cmd_dec_check u_check (
  .clk(clk), .rstN(rstN), .frameStb(frameStb), .frameWord(frameWord),
  .modeCtl(modeCtl), .cfgBank(cfgBank), .fifoClr(fifoClr)
);

// File: tb/sim_serial_cmd_decoder.sv
`timescale 1ns/1ps
module sim_serial_cmd_decoder;
  localparam int NREG = 7;
  localparam int DW   = 11;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, din = 1'b0;
  logic [14:0]        modeCtl;
  logic [NREG*DW-1:0] cfgBank;
  logic               fifoClr;

  int checks = 0, errors = 0, clrSeen = 0, clrExp = 0;
  logic [14:0] expMode;
  logic [NREG*DW-1:0] expBank;

  serial_cmd_decoder u0 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .din(din),
    .modeCtl(modeCtl), .cfgBank(cfgBank), .fifoClr(fifoClr)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (fifoClr) clrSeen++;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model from the requirements
  task automatic model(input logic [15:0] w);
    if (!w[15]) begin
      if (w[6:5] == 2'b10) begin
        expMode = 15'h0800; expBank = '0; clrExp++;           // R7
      end else begin
        expMode = {w[14:7], 2'b00, w[4:0]};                  // R3
        if (w[6:5] == 2'b01) clrExp++;                       // R6
      end
    end else if (w[14:11] < 4'd7) begin
      expBank[w[14:11]*DW +: DW] = w[10:0];                  // R4
    end
  endtask

  task automatic sendBits(input logic [15:0] w, input int nbits);
    csN = 1'b0; #50;
    for (int i = 0; i < nbits; i++) begin
      din = (i < 16) ? w[15-i] : 1'b0;
      #50 sclk = 1'b1; #50 sclk = 1'b0;
    end
    #50 csN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic sendWord(input logic [15:0] w);
    model(w);
    sendBits(w, 16);
  endtask

  task automatic checkAll(input string req);
    check(req, 128'(modeCtl), 128'(expMode));
    check(req, 128'(cfgBank), 128'(expBank));
    check(req, 128'(clrSeen), 128'(clrExp));
  endtask

  initial begin
    #(150000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    expMode = 15'h0800; expBank = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 mode default", 128'(modeCtl), 128'h0800);
    check("R1 bank default", 128'(cfgBank), 128'h0);
    check("R1 fifoClr low", 128'(fifoClr), 128'h0);

    // every target code, two payload patterns (R4, R5)
    for (int c = 0; c < 16; c++) begin
      sendWord({1'b1, 4'(c), 11'(c * 157 + 11'h2A3)});
      checkAll((c < 7) ? "R4 data write" : "R5 reserved code");
    end
    for (int c = 0; c < 16; c++) begin
      sendWord({1'b1, 4'(c), ~11'(c * 157 + 11'h2A3)});
      checkAll((c < 7) ? "R4 data rewrite" : "R5 reserved code");
    end

    // mode words across every reset field and scan field (R3, R6, R7, R8, R9)
    for (int rf = 0; rf < 4; rf++) begin
      for (int s = 0; s < 16; s++) begin
        sendWord({1'b1, 4'(s % 7), 11'(s * 73 + rf * 301 + 5)});
        sendWord({1'b0, 4'(s), 4'(15 - s), 2'(rf), 5'(s * 3 + rf)});
        case (rf)
          0: checkAll("R8 reset field 00");
          1: checkAll("R6 fifo-only clear");
          2: checkAll("R7 restore all");
          default: checkAll("R8 reset field 11");
        endcase
      end
    end

    // wrong-length frames (R2)
    sendWord({1'b1, 4'd3, 11'h155});
    sendWord({1'b0, 4'd9, 4'd6, 2'b00, 5'd17});
    checkAll("R2 baseline frame");
    sendBits({1'b1, 4'd3, 11'h2AA}, 15);
    checkAll("R2 short data frame");
    sendBits({1'b1, 4'd3, 11'h2AA}, 17);
    checkAll("R2 long data frame");
    sendBits({1'b0, 4'd2, 4'd1, 2'b10, 5'd0}, 15);
    checkAll("R2 short restore frame");
    sendBits({1'b0, 4'd2, 4'd1, 2'b01, 5'd0}, 17);
    checkAll("R2 long clear frame");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule